// File: doc/BRIEF.md
# BCD Real-Time Calendar Clock

This core keeps wall-clock time as six packed BCD bytes: seconds, minutes, hours on a 24-hour scale, day of month, month and a two-digit year that stands for 2000 to 2099. An enable input arrives at 32768 Hz. A prescaler counts those pulses and advances the calendar by one second each time it wraps. Carries ripple from seconds up to the year. Month length and leap years are taken into account when the day rolls over.

Software reaches the core through a simple byte-wide register port. Through it, software sets and reads the time, programs one alarm, starts and stops the count, and handles two event flags with write-one-to-clear. A status bit warns that a one-second update is imminent, and software should wait for it to drop before touching the time. The alarm needs every one of the six fields to match. Two registered interrupt lines report the per-second event and the alarm, each gated by its own enable.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 2000-01-01 00:00:00 (year 00, month 01, day 01, hours/minutes/seconds 00), all six alarm bytes read 00, the control, status and interrupt-enable registers read 00, and both interrupt outputs are low.
- R2: Offsets on the register port:
  - time field k (k=0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year) is at byte offset 4k;
  - the matching alarm field is at 0x20+4k;
  - control is at 0x40, status at 0x44 and interrupt enable at 0x48.
  
  Read data appears on `bus_rdata` one clock after the read is issued. An unmapped offset reads 00.
- R3: While control bit 0 is 1, seconds advance once per 2^PRESC_W pulses of `tick_en`. While it is 0, neither the time nor the prescaler moves. Status bit 1 reads back the run state.
- R4: Status bit 0 (busy) reads 1 exactly while the core is running and the prescaler sits on its last count, so that the next `tick_en` pulse will update the time. It reads 0 otherwise.
- R5: Seconds roll from 59 to 00 with a carry into minutes. Minutes roll from 59 to 00 with a carry into hours. Hours roll from 23 to 00 with a carry into the day.
- R6: The day rolls over to 01 after the last day of the month, with a carry into the month:
  - months 04, 06, 09 and 11 end at 30;
  - month 02 ends at 29 when the two-digit year is divisible by 4, and at 28 otherwise;
  - all other months end at 31.
  
  Month 12 rolls over to 01 with a carry into the year, and year 99 rolls over to 00.
- R7: A write to a time field loads that byte on the next clock. A write to the seconds field also clears the prescaler, so the next second arrives a full 2^PRESC_W pulses later.
- R8: Status bit 6 is set when the six time fields become equal to the six alarm fields. A mismatch in any single field prevents it from being set. It stays set until software writes a 1 to bit 6. Writing 0 to it has no effect.
- R9: Status bit 2 is set on every one-second update and is cleared by writing a 1 to bit 2.
- R10: `irq_timer` is the registered AND of interrupt-enable bit 2 and status bit 2. `irq_alarm` is the registered AND of interrupt-enable bit 3 and status bit 6. Each follows its sources one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse at 32768 Hz |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_timer | output | 1 | Per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The embedded properties check the following on every cycle:
- the prescaler stays frozen while stopped;
- busy holds until the update pulse arrives;
- seconds wrap at 59;
- the calendar is stable when there is neither a step nor a write;
- an alarm hit is a single-cycle edge that always sets the flag;
- each interrupt line follows its enable and flag.

Month-length and leap-year rollover, the century wrap, the need for all six alarm fields to match, the prescaler restart on a seconds write, and the write-one-to-clear semantics can only be shown by the bench's scenarios. The bench loads chosen dates and steps a single second past them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  typedef logic [7:0] bcd_t;
  typedef logic [NFIELD-1:0][7:0] cal_t;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_RUN   = 1;
  localparam int ST_TICK  = 2;
  localparam int ST_ALARM = 6;
  // interrupt enable bit positions
  localparam int IE_TICK  = 2;
  localparam int IE_ALARM = 3;

  function automatic bcd_t bcd_inc(input bcd_t v);
    bcd_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic bcd_leap(input bcd_t y);
    logic r;
    if (!y[4]) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction

  function automatic bcd_t month_last_day(input bcd_t m, input bcd_t y);
    bcd_t r;
    case (m)
      8'h02:                      r = bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick_en,
  input  logic clr,
  output logic sec_stb,
  output logic busy
);
  localparam logic [PRESC_W-1:0] LAST = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] cnt;

  assign busy    = run && (cnt == LAST);
  assign sec_stb = busy && tick_en && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (run && tick_en) cnt <= cnt + 1'b1;
  end

  a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));
  a_r4_busy_held_until_pulse: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick_en && !clr) |=> (cnt == LAST));
  a_r3_wrap_after_second: assert property (@(posedge clk) disable iff (rst)
    sec_stb |=> (cnt == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [NFIELD-1:0] wr_en,
  input  bcd_t              wr_data,
  output cal_t              now
);
  localparam cal_t RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  cal_t nxt;
  logic [NFIELD:0] carry;
  logic [NFIELD-1:0] at_top;
  bcd_t [NFIELD-1:0] top_val;
  bcd_t [NFIELD-1:0] wrap_val;

  always_comb begin
    top_val[F_SEC]   = 8'h59;
    top_val[F_MIN]   = 8'h59;
    top_val[F_HOUR]  = 8'h23;
    top_val[F_DAY]   = month_last_day(now[F_MON], now[F_YEAR]);
    top_val[F_MON]   = 8'h12;
    top_val[F_YEAR]  = 8'h99;
    wrap_val[F_SEC]  = 8'h00;
    wrap_val[F_MIN]  = 8'h00;
    wrap_val[F_HOUR] = 8'h00;
    wrap_val[F_DAY]  = 8'h01;
    wrap_val[F_MON]  = 8'h01;
    wrap_val[F_YEAR] = 8'h00;
  end

  assign carry[0] = step;

  genvar k;
  generate
    for (k = 0; k < NFIELD; k++) begin : g_field
      assign at_top[k]  = (now[k] >= top_val[k]);
      assign carry[k+1] = carry[k] && at_top[k];
      assign nxt[k]     = !carry[k] ? now[k] : (at_top[k] ? wrap_val[k] : bcd_inc(now[k]));

      always_ff @(posedge clk) begin
        if (rst)           now[k] <= RESET_TIME[k];
        else if (wr_en[k]) now[k] <= wr_data;
        else               now[k] <= nxt[k];
      end
    end
  endgenerate

  a_r5_seconds_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && now[F_SEC] == 8'h59 && !wr_en[F_SEC]) |=> (now[F_SEC] == 8'h00));
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!step && wr_en == '0) |=> $stable(now));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cal_t              now,
  input  logic [NFIELD-1:0] wr_en,
  input  bcd_t              wr_data,
  output cal_t              alarm,
  output logic              hit
);
  logic equal;
  logic equal_q;

  assign equal = (now == alarm);
  assign hit   = equal && !equal_q;

  genvar k;
  generate
    for (k = 0; k < NFIELD; k++) begin : g_alm
      always_ff @(posedge clk) begin
        if (rst)           alarm[k] <= 8'h00;
        else if (wr_en[k]) alarm[k] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) equal_q <= 1'b0;
    else     equal_q <= equal;
  end

  a_r8_hit_single_cycle: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESC_W = 15,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_timer,
  output logic              irq_alarm
);
  localparam logic [ADDR_W-1:0] OFS_ALARM = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] OFS_IE    = ADDR_W'(8'h48);

  logic wr_acc, rd_acc;
  logic [NFIELD-1:0] time_we, alarm_we;
  logic run, st_tick, st_alarm, ie_tick, ie_alarm;
  logic sec_stb, busy, alarm_hit;
  cal_t now, alarm;
  logic [7:0] status, rd_mux;

  assign wr_acc = bus_sel && bus_wr;
  assign rd_acc = bus_sel && !bus_wr;

  always_comb begin
    for (int k = 0; k < NFIELD; k++) begin
      time_we[k]  = wr_acc && (bus_addr == ADDR_W'(4 * k));
      alarm_we[k] = wr_acc && (bus_addr == OFS_ALARM + ADDR_W'(4 * k));
    end
  end

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .tick_en(tick_en),
    .clr(time_we[F_SEC]), .sec_stb(sec_stb), .busy(busy)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .step(sec_stb), .wr_en(time_we),
    .wr_data(bus_wdata), .now(now)
  );

  rtc_alarm_match u_alm (
    .clk(clk), .rst(rst), .now(now), .wr_en(alarm_we),
    .wr_data(bus_wdata), .alarm(alarm), .hit(alarm_hit)
  );

  // control, flags and enables
  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      st_tick  <= 1'b0;
      st_alarm <= 1'b0;
      ie_tick  <= 1'b0;
      ie_alarm <= 1'b0;
    end else begin
      if (wr_acc && bus_addr == OFS_CTRL) run <= bus_wdata[0];
      if (wr_acc && bus_addr == OFS_IE) begin
        ie_tick  <= bus_wdata[IE_TICK];
        ie_alarm <= bus_wdata[IE_ALARM];
      end
      if (sec_stb)                                          st_tick <= 1'b1;
      else if (wr_acc && bus_addr == OFS_STAT && bus_wdata[ST_TICK]) st_tick <= 1'b0;
      if (alarm_hit)                                         st_alarm <= 1'b1;
      else if (wr_acc && bus_addr == OFS_STAT && bus_wdata[ST_ALARM]) st_alarm <= 1'b0;
    end
  end

  always_comb begin
    status           = 8'h00;
    status[ST_BUSY]  = busy;
    status[ST_RUN]   = run;
    status[ST_TICK]  = st_tick;
    status[ST_ALARM] = st_alarm;
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int k = 0; k < NFIELD; k++) begin
      if (bus_addr == ADDR_W'(4 * k))             rd_mux = now[k];
      if (bus_addr == OFS_ALARM + ADDR_W'(4 * k)) rd_mux = alarm[k];
    end
    if (bus_addr == OFS_CTRL) rd_mux = {7'b0, run};
    if (bus_addr == OFS_STAT) rd_mux = status;
    if (bus_addr == OFS_IE)   rd_mux = {4'b0, ie_alarm, ie_tick, 2'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      irq_timer <= 1'b0;
      irq_alarm <= 1'b0;
    end else begin
      if (rd_acc) bus_rdata <= rd_mux;
      irq_timer <= ie_tick && st_tick;
      irq_alarm <= ie_alarm && st_alarm;
    end
  end

  a_r9_tick_sets_flag: assert property (@(posedge clk) disable iff (rst)
    sec_stb |=> st_tick);
  a_r8_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> st_alarm);
  a_r10_alarm_irq: assert property (@(posedge clk) disable iff (rst)
    irq_alarm == $past(ie_alarm && st_alarm));
  a_r10_timer_irq: assert property (@(posedge clk) disable iff (rst)
    irq_timer == $past(ie_tick && st_tick));
endmodule

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb;
  localparam int PW = 4;
  localparam int SEC = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq_timer, irq_alarm;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; logic [7:0] addr; int req; } exp_t;
  exp_t exp_q[$];
  logic rd_issue_d = 1'b0;

  always #2 clk = ~clk;

  bcd_rtc_core #(.PRESC_W(PW), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_timer(irq_timer), .irq_alarm(irq_alarm)
  );

  // monitor: compare registered read data against the scoreboard queue
  always @(posedge clk) rd_issue_d <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_issue_d) begin
      exp_t e;
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL read with empty scoreboard: actual %02h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        if (bus_rdata !== e.exp) begin
          nfail++;
          $display("FAIL R%0d addr %02h: actual %02h expected %02h", e.req, e.addr, bus_rdata, e.exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input int req);
    exp_t it;
    @(negedge clk);
    it.exp = e; it.addr = a; it.req = req;
    exp_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic chk_pin(input logic got, input logic e, input int req, input string nm);
    nchk++;
    if (got !== e) begin
      nfail++;
      $display("FAIL R%0d %s: actual %0b expected %0b", req, nm, got, e);
    end
  endtask

  // seconds written first (restarts prescaler), year last
  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h00, s); wr(8'h04, mi); wr(8'h08, h);
    wr(8'h0C, d); wr(8'h10, mo); wr(8'h14, y);
  endtask

  task automatic rd_time(input logic [7:0] y, mo, d, h, mi, s, input int req);
    rd(8'h00, s, req); rd(8'h04, mi, req); rd(8'h08, h, req);
    rd(8'h0C, d, req); rd(8'h10, mo, req); rd(8'h14, y, req);
  endtask

  // step one second across a boundary and check the resulting date
  task automatic roll(input logic [7:0] y, mo, d, input logic [7:0] ey, emo, ed, input int req);
    set_time(y, mo, d, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    rd_time(ey, emo, ed, 8'h00, 8'h00, 8'h00, req);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1);
    for (int k = 0; k < 6; k++) rd(8'h20 + 8'(4 * k), 8'h00, 1);
    rd(8'h40, 8'h00, 1); rd(8'h44, 8'h00, 1); rd(8'h48, 8'h00, 1);
    chk_pin(irq_timer, 1'b0, 1, "irq_timer"); // R1
    chk_pin(irq_alarm, 1'b0, 1, "irq_alarm"); // R1
    // R2 unmapped offset
    rd(8'h3C, 8'h00, 2);

    // R3 stopped: pulses do nothing
    pulses(3 * SEC);
    rd(8'h00, 8'h00, 3);

    // R3 run, R4 busy on last count, R9 tick flag
    wr(8'h40, 8'h01);
    rd(8'h40, 8'h01, 2); // R2 control readback
    rd(8'h44, 8'h02, 3);
    pulses(SEC - 1);
    rd(8'h44, 8'h03, 4);
    rd(8'h00, 8'h00, 3);
    pulses(1);
    rd(8'h00, 8'h01, 3);
    rd(8'h44, 8'h06, 9);
    chk_pin(irq_timer, 1'b0, 10, "irq_timer masked"); // R10
    wr(8'h44, 8'h04);
    rd(8'h44, 8'h02, 9);

    // R7 seconds write restarts the prescaler
    pulses(5);
    wr(8'h00, 8'h30);
    pulses(SEC - 1);
    rd(8'h00, 8'h30, 7);
    pulses(1);
    rd(8'h00, 8'h31, 7);
    wr(8'h0C, 8'h17);
    rd(8'h0C, 8'h17, 7);

    // R5 carry chain into the day
    set_time(8'h24, 8'h07, 8'h15, 8'h23, 8'h59, 8'h59);
    pulses(SEC);
    rd_time(8'h24, 8'h07, 8'h16, 8'h00, 8'h00, 8'h00, 5);
    set_time(8'h24, 8'h07, 8'h15, 8'h10, 8'h59, 8'h59);
    pulses(SEC);
    rd_time(8'h24, 8'h07, 8'h15, 8'h11, 8'h00, 8'h00, 5);

    // R6 month lengths, leap years, year wrap
    roll(8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29, 6);
    roll(8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01, 6);
    roll(8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01, 6);
    roll(8'h00, 8'h02, 8'h28, 8'h00, 8'h02, 8'h29, 6);
    roll(8'h10, 8'h02, 8'h28, 8'h10, 8'h03, 8'h01, 6);
    roll(8'h12, 8'h02, 8'h28, 8'h12, 8'h02, 8'h29, 6);
    roll(8'h23, 8'h04, 8'h30, 8'h23, 8'h05, 8'h01, 6);
    roll(8'h23, 8'h11, 8'h30, 8'h23, 8'h12, 8'h01, 6);
    roll(8'h23, 8'h01, 8'h30, 8'h23, 8'h01, 8'h31, 6);
    roll(8'h23, 8'h12, 8'h31, 8'h24, 8'h01, 8'h01, 6);
    roll(8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01, 6);

    // R8 alarm: program alarm 2025-06-10 08:30:05
    wr(8'h34, 8'h25); wr(8'h30, 8'h06); wr(8'h2C, 8'h10);
    wr(8'h28, 8'h08); wr(8'h24, 8'h30); wr(8'h20, 8'h05);
    rd(8'h30, 8'h06, 2); // R2 alarm readback
    wr(8'h44, 8'h44);
    wr(8'h48, 8'h08);
    // month differs: no alarm
    set_time(8'h25, 8'h07, 8'h10, 8'h08, 8'h30, 8'h04);
    pulses(SEC);
    rd(8'h44, 8'h06, 8);
    chk_pin(irq_alarm, 1'b0, 8, "irq_alarm mismatch");
    // full match
    set_time(8'h25, 8'h06, 8'h10, 8'h08, 8'h30, 8'h04);
    wr(8'h44, 8'h44);
    pulses(SEC);
    rd(8'h44, 8'h46, 8);
    chk_pin(irq_alarm, 1'b1, 10, "irq_alarm"); // R10
    wr(8'h44, 8'h00);
    rd(8'h44, 8'h46, 8);
    wr(8'h44, 8'h40);
    rd(8'h44, 8'h06, 8);
    chk_pin(irq_alarm, 1'b0, 8, "irq_alarm cleared");

    // R10 timer interrupt follows enable and flag
    wr(8'h48, 8'h0C);
    rd(8'h48, 8'h0C, 10);
    chk_pin(irq_timer, 1'b1, 10, "irq_timer");
    wr(8'h44, 8'h04);
    rd(8'h44, 8'h02, 9);
    chk_pin(irq_timer, 1'b0, 10, "irq_timer cleared");

    // R3 stopping freezes time
    wr(8'h40, 8'h00);
    pulses(3 * SEC);
    rd(8'h00, 8'h05, 3);
    rd(8'h44, 8'h00, 3);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      nchk++; nfail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule